// File: doc/BRIEF.md
# Bitwise Logic Execute Unit

This block executes the bitwise-logic instructions of a small 8-bit RISC core that uses 16-bit opcodes. It holds its own 32 x 8-bit register file. It accepts one instruction word per cycle, qualified by a valid strobe, and decodes it as one of five forms: AND, OR or XOR between two registers, and AND or OR between a register and an 8-bit constant. The result goes back into the destination register. The same edge updates four status flags.

The constant-operand forms can only reach the upper sixteen registers. Their constant and register fields are spread across the opcode word. Any word that matches none of the five forms leaves every register and flag as it was, and it raises a one-cycle illegal-opcode pulse. A combinational debug port lets a test or a debugger read any register, and the flags are always visible.

Top module: `lgx_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers and the flags to zero, and holds `illegal_o` low.
- R2: A word of the form `0110 KKKK dddd KKKK` ORs register 16+d with the constant K and writes the result back to register 16+d. K takes its upper nibble from bits [11:8] and its lower nibble from bits [3:0].
- R3: A word of the form `0111 KKKK dddd KKKK` ANDs register 16+d with the same constant K and writes the result back to register 16+d.
- R4: A word whose bits [15:10] are `001000` performs AND, `001001` performs XOR and `001010` performs OR. The destination index is bits [8:4] and the source index is {bit 9, bits [3:0]}. The result is written to the destination register.
- R5: The result can be read on the debug port in the cycle after the word is accepted. A word accepted in the very next cycle operates on the updated value.
- R6: `flags_o` is {S,V,N,Z} in bits 3..0. After every logic operation Z is 1 exactly when the result is zero, N equals result bit 7, V is 0 and S equals N.
- R7: A register may be both source and destination. XOR of a register with itself leaves it at zero and sets Z.
- R8: A valid word outside the five forms, including prefix `001011`, drives `illegal_o` high for the single cycle after acceptance and changes no register or flag.
- R9: While `insn_valid_i` is low, no register or flag changes and `illegal_o` stays low.
- R10: `dbg_data_o` shows, without a clock edge, the contents of the register selected by `dbg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 16 | Instruction word |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_data_o | output | 8 | Contents of the selected register |
| flags_o | output | 4 | Status flags {S,V,N,Z} |
| illegal_o | output | 1 | One-cycle pulse for an unrecognised word |

## Verification
Each accepted word is registered exactly once. The written register, the flags and the illegal pulse therefore all become valid one clock edge after the word is presented, and the debug read adds no further latency. The bench drives each word on a falling edge and applies it at the following rising edge. It samples every result on the next falling edge, and it reads the illegal pulse in that same half-cycle, before the next rising edge clears it. Back-to-back words are driven on consecutive falling edges, so the second word checks the forwarding of the first word's result through the register file with no bubble.

// File: rtl/lgx_pkg.sv
package lgx_pkg;

    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 32;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int INSN_W    = 16;
    localparam int IMM_BASE  = REG_COUNT / 2;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_XOR = 2'b01,
        LOP_OR  = 2'b10
    } lop_e;

    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        logic              legal;
        lop_e              op;
        logic              use_imm;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src;
        logic [DATA_W-1:0] imm;
    } dec_t;

    function automatic flags_t logic_flags(input logic [DATA_W-1:0] res);
        flags_t f;
        f.z = (res == '0);
        f.n = res[DATA_W-1];
        f.v = 1'b0;
        f.s = f.n ^ f.v;
        return f;
    endfunction

endpackage

// File: rtl/lgx_decode.sv
module lgx_decode
    import lgx_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    logic [3:0] imm_slot;

    always_comb begin
        imm_slot      = insn_i[7:4];
        dec_o         = '0;
        dec_o.op      = LOP_AND;
        dec_o.imm     = {insn_i[11:8], insn_i[3:0]};
        if (insn_i[15:13] == 3'b011) begin
            // constant forms: bit 12 picks AND (1) or OR (0)
            dec_o.legal   = 1'b1;
            dec_o.use_imm = 1'b1;
            dec_o.op      = insn_i[12] ? LOP_AND : LOP_OR;
            dec_o.dst     = IDX_W'(IMM_BASE) + IDX_W'(imm_slot);
            dec_o.src     = dec_o.dst;
        end else if (insn_i[15:12] == 4'b0010 && insn_i[11:10] != 2'b11) begin
            dec_o.legal   = 1'b1;
            dec_o.use_imm = 1'b0;
            dec_o.op      = lop_e'(insn_i[11:10]);
            dec_o.dst     = insn_i[8:4];
            dec_o.src     = {insn_i[9], insn_i[3:0]};
        end
    end

    always_comb begin
        if (dec_o.legal && dec_o.use_imm)
            a_imm_upper_r2 : assert (dec_o.dst >= IDX_W'(IMM_BASE));
    end

endmodule

// File: rtl/lgx_alu.sv
module lgx_alu
    import lgx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  lop_e         op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            LOP_AND: res_o = a_i & b_i;
            LOP_XOR: res_o = a_i ^ b_i;
            LOP_OR:  res_o = a_i | b_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/lgx_regfile.sv
module lgx_regfile #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    ra_i,
    output logic [WIDTH-1:0] ra_o,
    input  logic [AW-1:0]    rb_i,
    output logic [WIDTH-1:0] rb_o,
    input  logic [AW-1:0]    rc_i,
    output logic [WIDTH-1:0] rc_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we_i && waddr_i == AW'(g))
                mem[g] <= wdata_i;
        end
    end

    assign ra_o = mem[ra_i];
    assign rb_o = mem[rb_i];
    assign rc_o = mem[rc_i];

    p_write_lands_r5 : assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/lgx_exec_unit.sv
module lgx_exec_unit
    import lgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [IDX_W-1:0]  dbg_addr_i,
    output logic [DATA_W-1:0] dbg_data_o,
    output logic [3:0]        flags_o,
    output logic              illegal_o
);
    dec_t              dec;
    logic [DATA_W-1:0] opa, opb_reg, opb, res;
    logic              commit;
    flags_t            flags_q;
    logic              illegal_q;

    lgx_decode u_dec (.insn_i(insn_i), .dec_o(dec));

    lgx_regfile #(.WIDTH(DATA_W), .DEPTH(REG_COUNT)) u_rf (
        .clk(clk), .rst(rst),
        .we_i(commit), .waddr_i(dec.dst), .wdata_i(res),
        .ra_i(dec.dst), .ra_o(opa),
        .rb_i(dec.src), .rb_o(opb_reg),
        .rc_i(dbg_addr_i), .rc_o(dbg_data_o)
    );

    assign opb    = dec.use_imm ? dec.imm : opb_reg;
    assign commit = insn_valid_i && dec.legal;

    lgx_alu #(.W(DATA_W)) u_alu (.op_i(dec.op), .a_i(opa), .b_i(opb), .res_o(res));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= insn_valid_i && !dec.legal;
            if (commit)
                flags_q <= logic_flags(res);
        end
    end

    assign flags_o   = flags_q;
    assign illegal_o = illegal_q;

    p_flags_rule_r6 : assert property (@(posedge clk) disable iff (rst)
        commit |=> (flags_o[2] == 1'b0) && (flags_o[3] == flags_o[1]));

    p_illegal_hold_r8 : assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !dec.legal) |=> illegal_o && $stable(flags_o));

    p_idle_quiet_r9 : assert property (@(posedge clk) disable iff (rst)
        !insn_valid_i |=> !illegal_o && $stable(flags_o));

    p_illegal_cause_r8 : assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(insn_valid_i));

endmodule

// File: tb/lgx_exec_unit_tb_top.sv
`timescale 1ns/1ps
module lgx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_valid_i;
    logic [15:0] insn_i;
    logic [4:0]  dbg_addr_i;
    logic [7:0]  dbg_data_o;
    logic [3:0]  flags_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] model [32];
    logic [3:0] mflags;
    logic       mill;

    always #10 clk = ~clk;

    lgx_exec_unit dut_i (
        .clk(clk), .rst(rst), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
        .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o),
        .flags_o(flags_o), .illegal_o(illegal_o)
    );

    // expected behaviour built from the requirement text
    task automatic model_apply(input logic [15:0] w);
        logic [4:0] d, s;
        logic [7:0] b, r;
        int op; // 0 and, 1 xor, 2 or, -1 illegal
        op = -1;
        if (w[15:12] == 4'b0110 || w[15:12] == 4'b0111) begin
            d  = 5'd16 + {1'b0, w[7:4]};
            b  = {w[11:8], w[3:0]};
            op = w[12] ? 0 : 2;
        end else if (w[15:10] == 6'b001000 || w[15:10] == 6'b001001 || w[15:10] == 6'b001010) begin
            d  = w[8:4];
            s  = {w[9], w[3:0]};
            b  = model[s];
            op = int'(w[11:10]);
        end
        mill = (op < 0);
        if (op >= 0) begin
            r = (op == 0) ? (model[d] & b) : (op == 1) ? (model[d] ^ b) : (model[d] | b);
            model[d] = r;
            mflags = {r[7], 1'b0, r[7], (r == 8'h00)};
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input int idx);
        dbg_addr_i = 5'(idx);
        #1;
        check(tag, {24'h0, dbg_data_o}, {24'h0, model[idx]});
    endtask

    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        insn_i = w;
        insn_valid_i = 1'b1;
        model_apply(w);
    endtask

    task automatic settle();
        @(negedge clk);
        insn_valid_i = 1'b0;
        insn_i = 16'h0000;
    endtask

    function automatic logic [15:0] imm_w(input bit is_and, input int reg_hi, input logic [7:0] k);
        return {3'b011, is_and, k[7:4], 4'(reg_hi - 16), k[3:0]};
    endfunction

    function automatic logic [15:0] reg_w(input logic [1:0] sub, input int d, input int s);
        logic [4:0] dd, ss;
        dd = 5'(d);
        ss = 5'(s);
        return {4'b0010, sub, ss[4], dd, ss[3:0]};
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        mflags = 4'h0;
        rst = 1'b1;
        insn_valid_i = 1'b0;
        insn_i = 16'h0;
        dbg_addr_i = 5'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reg("R1 reg0 after reset", 0);
        check_reg("R1 reg31 after reset", 31);
        check("R1 flags after reset", {28'h0, flags_o}, 32'h0);
        check("R1 illegal after reset", {31'h0, illegal_o}, 32'h0);
    endtask

    task automatic t_imm_or();
        for (int i = 16; i < 32; i++) begin
            issue(imm_w(1'b0, i, 8'(i * 37 + 5)));
            settle();
            check_reg("R2 ori writes 16+d", i);
            check("R6 flags after ori", {28'h0, flags_o}, {28'h0, mflags});
        end
        issue(imm_w(1'b0, 20, 8'hA0));
        settle();
        check_reg("R2 ori merges with existing value", 20);
        check_reg("R2 ori leaves reg4 alone", 4);
    endtask

    task automatic t_imm_and();
        issue(imm_w(1'b1, 17, 8'h0F));
        settle();
        check_reg("R3 andi result", 17);
        check("R3 flags after andi", {28'h0, flags_o}, {28'h0, mflags});
        issue(imm_w(1'b1, 18, 8'h00));
        settle();
        check_reg("R3 andi to zero", 18);
        check("R6 Z set on zero", {28'h0, flags_o}, 32'h1);
        issue(imm_w(1'b1, 31, 8'hF0));
        settle();
        check_reg("R3 andi reg31", 31);
    endtask

    task automatic t_reg_ops();
        for (int i = 0; i < 16; i++) begin
            issue(reg_w(2'b10, i, 16 + i));
            settle();
            check_reg("R4 or into low register", i);
        end
        issue(reg_w(2'b00, 3, 27));
        settle();
        check_reg("R4 and reg-reg", 3);
        check("R6 flags after and", {28'h0, flags_o}, {28'h0, mflags});
        issue(reg_w(2'b01, 22, 9));
        settle();
        check_reg("R4 xor reg-reg high dst", 22);
        check("R6 flags after xor", {28'h0, flags_o}, {28'h0, mflags});
        issue(imm_w(1'b0, 25, 8'h80));
        settle();
        check("R6 N and S follow bit7", {28'h0, flags_o}, {28'h0, mflags});
    endtask

    task automatic t_back_to_back();
        issue(imm_w(1'b0, 16, 8'h81));
        issue(reg_w(2'b10, 5, 16));
        issue(reg_w(2'b01, 29, 5));
        settle();
        check_reg("R5 chained reg16", 16);
        check_reg("R5 chained reg5", 5);
        check_reg("R5 chained reg29", 29);
        check("R5 flags from last word", {28'h0, flags_o}, {28'h0, mflags});
    endtask

    task automatic t_self_xor();
        issue(reg_w(2'b01, 12, 12));
        settle();
        check_reg("R7 xor self clears", 12);
        check("R7 Z after self xor", {28'h0, flags_o}, 32'h1);
        issue(reg_w(2'b10, 23, 23));
        settle();
        check_reg("R7 or self keeps", 23);
    endtask

    task automatic t_illegal();
        logic [15:0] bad [4];
        bad[0] = reg_w(2'b11, 7, 19);
        bad[1] = 16'h0000;
        bad[2] = 16'hFFFF;
        bad[3] = 16'h8123;
        issue(imm_w(1'b0, 26, 8'h7E));
        settle();
        for (int i = 0; i < 4; i++) begin
            issue(bad[i]);
            check("R8 model sees illegal", {31'h0, mill}, 32'h1);
            settle();
            check("R8 illegal pulse", {31'h0, illegal_o}, 32'h1);
            check("R8 flags unchanged", {28'h0, flags_o}, {28'h0, mflags});
            check_reg("R8 dst of 001011 untouched", 7);
            @(negedge clk);
            check("R8 pulse one cycle", {31'h0, illegal_o}, 32'h0);
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        insn_i = reg_w(2'b01, 26, 26);
        insn_valid_i = 1'b0;
        @(negedge clk);
        check_reg("R9 no write while invalid", 26);
        check("R9 flags hold while invalid", {28'h0, flags_o}, {28'h0, mflags});
        check("R9 no illegal while invalid", {31'h0, illegal_o}, 32'h0);
        insn_i = 16'hFFFF;
        @(negedge clk);
        check("R9 junk word ignored", {31'h0, illegal_o}, 32'h0);
        insn_i = 16'h0;
    endtask

    task automatic t_debug_sweep();
        for (int i = 0; i < 32; i++) check_reg("R10 debug read", i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_imm_or();
        t_imm_and();
        t_reg_ops();
        t_back_to_back();
        t_self_xor();
        t_illegal();
        t_idle();
        t_debug_sweep();
        t_reset();
        t_debug_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule